// File: doc/BRIEF.md
# Padded long byte-move engine

This engine copies a byte field from a source region to a destination region of a 24-bit byte-addressed memory, one byte at a time, in ascending address order. Each operand is given as an address word and a length word. The length sits in the low 24 bits of its word. The high byte of the source length word supplies the fill byte. When the source runs out before the destination is full, the remaining destination bytes receive the fill byte. Addresses advance modulo 2^24, so a field may run past the top of memory and continue at address 0.

After a start pulse the engine spends one cycle classifying the request. It compares the two lengths to form a condition code. It also tests whether the first destination byte would land on a source byte that has still to be read. If so, it refuses to move anything and reports code 3. Otherwise it copies each byte with a read cycle followed by a write cycle, and each fill byte takes one write cycle. An interrupt request is looked at before every byte transfer. When it is high the engine stops and returns address and length words that describe the progress so far, so that starting again with those words completes the job.

Top module: `padmove_engine`

## Requirements
- R1: A length is bits [23:0] of its length word. The fill byte is bits [31:24] of the source length word. Bits [31:24] of both returned length words equal those of the words given at start. Bits [31:24] of both returned address words are always zero.
- R2: Destination byte k receives source byte k (address src+k) for k below the smaller length. A copied byte is read in one cycle and written in the next cycle. mem_rd and mem_wr are never high together.
- R3: When the source length is smaller than the destination length, each destination byte from index src_len upward is written with the fill byte.
- R4: When the operation is not refused and not interrupted, cc_o is 0 when the lengths are equal, 1 when the destination length is smaller and 2 when it is larger.
- R5: Let n be the smaller of the two lengths. The request is refused with cc_o = 3 when dst = src+k (mod 2^24) for some k with 1 <= k <= n-1. A refused request performs no memory access and returns the lengths and the address low bits unchanged.
- R6: Addresses wrap from 0xFFFFFF to 0x000000, both for the bytes transferred and for the overlap test.
- R7: A zero destination length causes no memory access and gives cc_o 0 or 1 according to R4.
- R8: At completion the destination length is 0 and the destination address has advanced by the original destination length. The source length and address have changed by the number of source bytes read.
- R9: irq is sampled before each byte transfer. When it is high, no further transfer happens, done_o and interrupted_o rise together, and the words reflect the bytes moved so far. If the stop happens while filling, the source length is 0 and the source address has advanced by the full original source length.
- R10: done_o is a one-cycle pulse. Between start and done, busy_o is high. In idle after reset, done_o, busy_o, mem_rd and mem_wr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation using the four input words (accepted only when idle) |
| irq | input | 1 | Interrupt request, sampled before each byte transfer |
| dst_addr_i | input | 32 | Destination address word; bits [23:0] are the address |
| dst_len_i | input | 32 | Destination length word; bits [23:0] are the length |
| src_addr_i | input | 32 | Source address word; bits [23:0] are the address |
| src_len_i | input | 32 | Source length word; [23:0] length, [31:24] fill byte |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| interrupted_o | output | 1 | Last operation stopped on irq (cc_o is then meaningless) |
| cc_o | output | 2 | Condition code |
| dst_addr_o | output | 32 | Updated destination address word |
| dst_len_o | output | 32 | Updated destination length word |
| src_addr_o | output | 32 | Updated source address word |
| src_len_o | output | 32 | Updated source length word |

## Verification
The hardest situation to reach is an interrupt that lands exactly between two chosen transfers, and above all one that lands inside the fill phase. The bench counts the write strobes as they happen and raises irq half a cycle after the k-th write. The engine then sees the request at its next transfer decision, and the expected words follow directly from k. Overlap cases that straddle the wrap point come from vectors with the source placed just below 0xFFFFFF and the destination just above 0. A non-destructive case with the destination one full field above the source checks the boundary of the overlap window.

// File: rtl/padmove_pkg.sv
package padmove_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 32;
  localparam int DATA_W = 8;
  localparam int HI_W   = WORD_W - ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_WRITE, S_PAD, S_FIN
  } mv_state_t;

  function automatic addr_t min_len(addr_t a, addr_t b);
    return (a < b) ? a : b;
  endfunction

  // 0 equal, 1 destination shorter, 2 destination longer
  function automatic logic [1:0] len_code(addr_t dl, addr_t sl);
    if (dl == sl) return 2'd0;
    else if (dl < sl) return 2'd1;
    else return 2'd2;
  endfunction

  // destination start hits an unread source byte: offset (mod 2^24) in [1, n-1]
  function automatic logic overlap_bad(addr_t d, addr_t s, addr_t n);
    addr_t off;
    off = d - s;
    return (n != '0) && (off != '0) && (off < n);
  endfunction
endpackage

// File: rtl/padmove_check.sv
module padmove_check
  import padmove_pkg::*;
(
  input  addr_t      d_addr,
  input  addr_t      d_len,
  input  addr_t      s_addr,
  input  addr_t      s_len,
  output logic [1:0] cmp_code,
  output logic       ovl_hit,
  output logic       dst_zero
);
  addr_t n_part;

  always_comb begin
    n_part   = min_len(d_len, s_len);
    cmp_code = len_code(d_len, s_len);
    ovl_hit  = overlap_bad(d_addr, s_addr, n_part);
    dst_zero = (d_len == '0);
  end

  always_comb begin
    // R7: a zero destination length can never be judged destructive
    assert_zero_no_ovl_R7: assert (!(dst_zero && ovl_hit));
  end
endmodule

// File: rtl/padmove_seq.sv
module padmove_seq
  import padmove_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              irq,
  input  logic [WORD_W-1:0] dst_addr_i,
  input  logic [WORD_W-1:0] dst_len_i,
  input  logic [WORD_W-1:0] src_addr_i,
  input  logic [WORD_W-1:0] src_len_i,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [1:0]        cmp_code,
  input  logic              ovl_hit,
  input  logic              dst_zero,
  output addr_t             cur_d_addr,
  output addr_t             cur_d_len,
  output addr_t             cur_s_addr,
  output addr_t             cur_s_len,
  output addr_t             mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy_o,
  output logic              done_o,
  output logic              interrupted_o,
  output logic [1:0]        cc_o,
  output logic [WORD_W-1:0] dst_addr_o,
  output logic [WORD_W-1:0] dst_len_o,
  output logic [WORD_W-1:0] src_addr_o,
  output logic [WORD_W-1:0] src_len_o
);
  mv_state_t       st;
  addr_t           d_a, d_l, s_a, s_l;
  logic [HI_W-1:0] d_hi, s_hi;
  logic [1:0]      cc_r;
  logic            intr_r;

  // named events for the assertions
  logic copy_wr, pad_wr, stop_now;
  assign copy_wr  = (st == S_WRITE);
  assign pad_wr   = (st == S_PAD) && !irq;
  assign stop_now = ((st == S_READ) || (st == S_PAD)) && irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      d_a    <= '0; d_l <= '0; s_a <= '0; s_l <= '0;
      d_hi   <= '0; s_hi <= '0;
      cc_r   <= 2'd0;
      intr_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          d_a    <= dst_addr_i[ADDR_W-1:0];
          d_l    <= dst_len_i[ADDR_W-1:0];
          s_a    <= src_addr_i[ADDR_W-1:0];
          s_l    <= src_len_i[ADDR_W-1:0];
          d_hi   <= dst_len_i[WORD_W-1:ADDR_W];
          s_hi   <= src_len_i[WORD_W-1:ADDR_W];
          intr_r <= 1'b0;
          st     <= S_CHECK;
        end
        S_CHECK: begin
          cc_r <= ovl_hit ? 2'd3 : cmp_code;
          if (ovl_hit || dst_zero) st <= S_FIN;
          else if (s_l == '0)      st <= S_PAD;
          else                     st <= S_READ;
        end
        S_READ: begin
          if (irq) begin
            intr_r <= 1'b1;
            st     <= S_FIN;
          end else begin
            st <= S_WRITE;
          end
        end
        S_WRITE: begin
          d_a <= d_a + 1'b1;
          s_a <= s_a + 1'b1;
          d_l <= d_l - 1'b1;
          s_l <= s_l - 1'b1;
          if (d_l == addr_t'(1))      st <= S_FIN;
          else if (s_l == addr_t'(1)) st <= S_PAD;
          else                        st <= S_READ;
        end
        S_PAD: begin
          if (irq) begin
            intr_r <= 1'b1;
            st     <= S_FIN;
          end else begin
            d_a <= d_a + 1'b1;
            d_l <= d_l - 1'b1;
            if (d_l == addr_t'(1)) st <= S_FIN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr      = (st == S_READ) ? s_a : d_a;
  assign mem_rd        = (st == S_READ) && !irq;
  assign mem_wr        = copy_wr || pad_wr;
  assign mem_wdata     = (st == S_PAD) ? s_hi : mem_rdata;
  assign busy_o        = (st != S_IDLE);
  assign done_o        = (st == S_FIN);
  assign interrupted_o = intr_r;
  assign cc_o          = cc_r;
  assign cur_d_addr    = d_a;
  assign cur_d_len     = d_l;
  assign cur_s_addr    = s_a;
  assign cur_s_len     = s_l;
  assign dst_addr_o    = {{HI_W{1'b0}}, d_a};
  assign src_addr_o    = {{HI_W{1'b0}}, s_a};
  assign dst_len_o     = {d_hi, d_l};
  assign src_len_o     = {s_hi, s_l};

  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> copy_wr);
  assert_pad_after_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_wr |-> (s_l == '0));
  assert_ovl_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && ovl_hit) |=> (!mem_rd && !mem_wr && done_o && cc_o == 2'd3));
  assert_zero_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && dst_zero) |=> (!mem_rd && !mem_wr && done_o));
  assert_write_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (d_l == $past(d_l) - 1'b1));
  assert_hi_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> ($stable(d_hi) && $stable(s_hi)));
  assert_irq_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> (done_o && interrupted_o));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/padmove_engine.sv
module padmove_engine
  import padmove_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              irq,
  input  logic [WORD_W-1:0] dst_addr_i,
  input  logic [WORD_W-1:0] dst_len_i,
  input  logic [WORD_W-1:0] src_addr_i,
  input  logic [WORD_W-1:0] src_len_i,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy_o,
  output logic              done_o,
  output logic              interrupted_o,
  output logic [1:0]        cc_o,
  output logic [WORD_W-1:0] dst_addr_o,
  output logic [WORD_W-1:0] dst_len_o,
  output logic [WORD_W-1:0] src_addr_o,
  output logic [WORD_W-1:0] src_len_o
);
  addr_t      cur_d_addr, cur_d_len, cur_s_addr, cur_s_len;
  logic [1:0] cmp_code;
  logic       ovl_hit, dst_zero;

  padmove_check u_check (
    .d_addr   (cur_d_addr),
    .d_len    (cur_d_len),
    .s_addr   (cur_s_addr),
    .s_len    (cur_s_len),
    .cmp_code (cmp_code),
    .ovl_hit  (ovl_hit),
    .dst_zero (dst_zero)
  );

  padmove_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .irq           (irq),
    .dst_addr_i    (dst_addr_i),
    .dst_len_i     (dst_len_i),
    .src_addr_i    (src_addr_i),
    .src_len_i     (src_len_i),
    .mem_rdata     (mem_rdata),
    .cmp_code      (cmp_code),
    .ovl_hit       (ovl_hit),
    .dst_zero      (dst_zero),
    .cur_d_addr    (cur_d_addr),
    .cur_d_len     (cur_d_len),
    .cur_s_addr    (cur_s_addr),
    .cur_s_len     (cur_s_len),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_wdata     (mem_wdata),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .interrupted_o (interrupted_o),
    .cc_o          (cc_o),
    .dst_addr_o    (dst_addr_o),
    .dst_len_o     (dst_len_o),
    .src_addr_o    (src_addr_o),
    .src_len_o     (src_len_o)
  );
endmodule

// File: tb/tb_padmove_engine.sv
`timescale 1ns/1ps
module tb_padmove_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        irq = 1'b0;
  logic [31:0] dst_addr_i = '0, dst_len_i = '0, src_addr_i = '0, src_len_i = '0;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic        busy_o, done_o, interrupted_o;
  logic [1:0]  cc_o;
  logic [31:0] dst_addr_o, dst_len_o, src_addr_o, src_len_o;

  always #2.5 clk = ~clk;

  padmove_engine dut (.*);

  int n_chk = 0, n_err = 0;
  longint cyc = 0;

  logic [7:0] mem [int];
  int wr_cnt = 0;
  int irq_after = 0;

  function automatic logic [7:0] init_b(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] rd_b(logic [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return init_b(a);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (mem_rd) mem_rdata <= rd_b(mem_addr);
  end

  always @(negedge clk)
    if (irq_after != 0 && wr_cnt >= irq_after) irq <= 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // fields: dst addr word, dst len, src addr word, src len, fill byte
  localparam int NV = 12;
  localparam logic [119:0] VEC [NV] = '{
    {32'hA5001000, 24'd8,  32'h77002000, 24'd8,  8'h11},  // equal
    {32'hA5001100, 24'd5,  32'h77002100, 24'd9,  8'h22},  // dst shorter
    {32'hA5001200, 24'd10, 32'h77002200, 24'd4,  8'hEE},  // fill
    {32'hA5001300, 24'd6,  32'h77002300, 24'd0,  8'h5A},  // all fill
    {32'hA5001400, 24'd0,  32'h77002400, 24'd3,  8'h01},  // zero dst
    {32'hA5001500, 24'd0,  32'h77002500, 24'd0,  8'h02},  // both zero
    {32'hA5003002, 24'd6,  32'h77003000, 24'd6,  8'h03},  // destructive
    {32'hA5000001, 24'd5,  32'h77FFFFFE, 24'd5,  8'h04},  // destructive across wrap
    {32'hA5004005, 24'd8,  32'h77004000, 24'd5,  8'h99},  // dst = src + n, allowed
    {32'hA5005000, 24'd4,  32'h77005000, 24'd4,  8'h06},  // same start
    {32'hA5FFFFFD, 24'd6,  32'h77008000, 24'd6,  8'h07},  // dst wraps
    {32'hA5006000, 24'd6,  32'h77006002, 24'd6,  8'h08}   // dst below src, allowed
  };

  task automatic run_op(input logic [31:0] da, input logic [23:0] dl,
                        input logic [31:0] sa, input logic [23:0] sl,
                        input logic [7:0] pad, input int stop_k, input string tag);
    logic [7:0]  snap [64];
    logic [23:0] d24, s24, n, k_done, k_src, off;
    logic [1:0]  exp_cc;
    bit hit, got;
    d24 = da[23:0]; s24 = sa[23:0];
    n = (dl < sl) ? dl : sl;
    for (int j = 0; j < 64; j++) snap[j] = rd_b(s24 + 24'(j));
    hit = 1'b0;
    for (int k = 1; k < int'(n); k++)
      if (24'(s24 + 24'(k)) == d24) hit = 1'b1;
    exp_cc = hit ? 2'd3 : (dl == sl) ? 2'd0 : (dl < sl) ? 2'd1 : 2'd2;
    @(negedge clk);
    wr_cnt = 0; irq = 1'b0; irq_after = stop_k;
    dst_addr_i = da; dst_len_i = {8'hC3, dl};
    src_addr_i = sa; src_len_i = {pad, sl};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int t = 0; t < 2000; t++) begin
      if (done_o) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R10", {tag, " done seen"}, 32'(got), 32'd1);
    if (hit) k_done = 0;
    else if (stop_k != 0 && stop_k < int'(dl)) k_done = 24'(stop_k);
    else k_done = dl;
    k_src = (k_done < sl) ? k_done : sl;
    chk(interrupted_o == (stop_k != 0 && !hit && k_done < dl), "R9",
        {tag, " interrupted"}, 32'(interrupted_o), 32'(stop_k != 0 && !hit && k_done < dl));
    if (stop_k == 0) begin
      chk(cc_o == exp_cc, hit ? "R5" : (dl == 0 ? "R7" : "R4"), {tag, " cc"},
          32'(cc_o), 32'(exp_cc));
    end
    chk(dst_addr_o == {8'h00, 24'(d24 + k_done)}, "R8", {tag, " dst addr"},
        dst_addr_o, {8'h00, 24'(d24 + k_done)});
    chk(dst_len_o == {8'hC3, 24'(dl - k_done)}, "R1", {tag, " dst len"},
        dst_len_o, {8'hC3, 24'(dl - k_done)});
    chk(src_addr_o == {8'h00, 24'(s24 + k_src)}, "R6", {tag, " src addr"},
        src_addr_o, {8'h00, 24'(s24 + k_src)});
    chk(src_len_o == {pad, 24'(sl - k_src)}, "R9", {tag, " src len"},
        src_len_o, {pad, 24'(sl - k_src)});
    chk(wr_cnt == int'(k_done), hit ? "R5" : "R2", {tag, " write count"},
        32'(wr_cnt), 32'(k_done));
    for (int j = 0; j < int'(k_done); j++) begin
      logic [7:0] e;
      e = (24'(j) < sl) ? snap[j] : pad;
      chk(rd_b(d24 + 24'(j)) == e, (24'(j) < sl) ? "R2" : "R3", {tag, " dst byte"},
          32'(rd_b(d24 + 24'(j))), 32'(e));
    end
    irq_after = 0;
    @(negedge clk);
    irq = 1'b0;
    chk(!done_o, "R10", {tag, " done one cycle"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !busy_o, "R10", "reset idle", {30'd0, done_o, busy_o}, 32'd0);
    chk(!mem_rd && !mem_wr, "R10", "reset no access", {30'd0, mem_rd, mem_wr}, 32'd0);
    for (int v = 0; v < NV; v++)
      run_op(VEC[v][119:88], VEC[v][87:64], VEC[v][63:32], VEC[v][31:8],
             VEC[v][7:0], 0, $sformatf("vec%0d", v));
    // R9: stop during copy after three bytes
    run_op(32'h00009000, 24'd8, 32'h0000A000, 24'd8, 8'h44, 3, "irq copy");
    // R9: stop during fill; source consumed entirely
    run_op(32'h00009100, 24'd8, 32'h0000A100, 24'd2, 8'h55, 5, "irq fill");
    // R9: resume the remaining fill and finish
    run_op(32'h00009105, 24'd3, 32'h0000A102, 24'd0, 8'h55, 0, "resume fill");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog: actual %0d expected below 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule